// File: doc/BRIEF.md
# Two-way write-back data cache with one recency bit per index

This block is a small data cache placed between a processor load/store port and a word-wide backing memory. It has four index lines. Each index has two ways, called left (way 0) and right (way 1), and each way holds one 32-bit word with its tag, a valid flag and a dirty flag. A single recency bit per index records which way was touched last. That bit chooses the victim when a read miss finds both ways occupied.

Writes that hit stay in the cache and mark the word dirty. Writes that miss go straight to memory and allocate nothing. A dirty word reaches memory only when a read miss evicts it. In that case the old word is written back before the fill read is issued. An invalidate request drops a matching word without writing it back, and it leaves the recency bit unchanged.

The processor side accepts one request at a time. `req_ready` stays low until the request completes, and completion is marked by a one-cycle `rsp_valid` pulse. The memory side issues one request at a time and holds it until the backing store accepts it. A read then waits for a separate response pulse.

Top module: `wbc_cache`

## Requirements
- R1: After reset every way is invalid and every recency bit is 0. `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: A read (`req_op` = 0) whose tag matches a valid way returns that way's word in `rsp_rdata`. It causes no memory request.
- R3: On a read miss, if a way at the index is invalid, the word is fetched from memory into an invalid way, and the left way is used when both are invalid. The fetched word is returned.
- R4: On a read miss with both ways valid, the way not used most recently is replaced. A recency bit of 1 means the left way was used last, so the right way is replaced; a bit of 0 replaces the left way.
- R5: A read hit, a write hit or a fill sets the index's recency bit to point at the way it used.
- R6: An invalidate (`req_op` = 2 or 3) that matches a valid way clears its valid flag and discards its word without any memory write. It leaves the recency bit unchanged. An invalidate that matches nothing has no effect.
- R7: A write miss (`req_op` = 1) issues exactly one memory write of `req_wdata` to the request address and leaves the cache unchanged.
- R8: A write hit replaces the cached word and marks it dirty, with no memory request.
- R9: When the victim of a read miss is dirty, its word is written to address {victim tag, index, 00} before the fill read is issued. A clean victim causes no memory write.
- R10: `req_ready` drops in the cycle after a request is accepted and returns together with a one-cycle `rsp_valid` pulse that marks completion.
- R11: A memory request keeps its valid, write flag, address and data stable until `mem_req_ready` accepts it. A read completes when `mem_rsp_valid` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache idle; a request is taken when this and req_valid are both high |
| req_op | input | 2 | 0 read, 1 write, 2 or 3 invalidate |
| req_addr | input | ADDR_W | Byte address: tag above bit 3, index in bits 3:2 |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read result, meaningful with rsp_valid after a read |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Word-aligned memory address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | DATA_W | Returned read data |

## Verification
The hardest situation to reach from the ports is a dirty victim that is then evicted. It needs two fills at one index, a write hit to one of them, and a later read miss whose recency state points at the dirty way. The case where an invalid way must override the recency bit is just as hard, because it needs an invalidate to follow a write hit. Directed sequences build both cases at index 0. A constrained-random stream follows, using only four tags per index so that conflicts, dirty evictions and invalidates recur often. A bench reference model predicts every read result, every memory write and the final memory contents.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
   typedef enum logic [1:0] {
      OP_RD   = 2'd0,
      OP_WR   = 2'd1,
      OP_INV  = 2'd2,
      OP_INVB = 2'd3
   } wbc_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LOOK,
      S_WB,
      S_FETCH,
      S_WAIT,
      S_WMISS
   } wbc_state_e;
endpackage

// File: rtl/wbc_way.sv
module wbc_way #(
   parameter int TAG_W  = 28,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              inv_en,
   output logic              valid,
   output logic              dirty,
   output logic [TAG_W-1:0]  tag,
   output logic [DATA_W-1:0] data
);
   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0]  v_q;
   logic [LINES-1:0]  d_q;
   logic [TAG_W-1:0]  tag_q [LINES];
   logic [DATA_W-1:0] dat_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
         d_q <= '0;
         for (int i = 0; i < LINES; i++) begin
            tag_q[i] <= '0;
            dat_q[i] <= '0;
         end
      end else if (fill_en) begin
         v_q[idx]   <= 1'b1;
         d_q[idx]   <= 1'b0;
         tag_q[idx] <= fill_tag;
         dat_q[idx] <= fill_data;
      end else if (wr_en) begin
         d_q[idx]   <= 1'b1;
         dat_q[idx] <= wr_data;
      end else if (inv_en) begin
         v_q[idx] <= 1'b0;
         d_q[idx] <= 1'b0;
      end
   end

   assign valid = v_q[idx];
   assign dirty = d_q[idx];
   assign tag   = tag_q[idx];
   assign data  = dat_q[idx];
endmodule

// File: rtl/wbc_lru.sv
module wbc_lru #(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             touch_en,
   input  logic             touch_left,
   output logic             mru_left
);
   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0] l_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         l_q <= '0;
      else if (touch_en)
         l_q[idx] <= touch_left;
   end

   assign mru_left = l_q[idx];
endmodule

// File: rtl/wbc_pick.sv
module wbc_pick (
   input  logic valid_l,
   input  logic valid_r,
   input  logic mru_left,
   output logic pick_right
);
   always_comb begin
      if (!valid_l)
         pick_right = 1'b0;
      else if (!valid_r)
         pick_right = 1'b1;
      else
         pick_right = mru_left;
   end
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
   import wbc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 2,
   parameter int OFF_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_rdata
);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
   localparam int WAYS  = 2;

   if (TAG_W < 1) begin : g_bad_split
      $error("wbc_cache: ADDR_W leaves no tag bits");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("wbc_cache: IDX_W must be at least 1");
   end

   wbc_state_e        state, nxt;
   logic [1:0]        q_op;
   logic [TAG_W-1:0]  q_tag;
   logic [IDX_W-1:0]  q_idx;
   logic [DATA_W-1:0] q_wdata;
   logic              victim_q;

   logic [WAYS-1:0]   w_valid, w_dirty, hit;
   logic [TAG_W-1:0]  w_tag  [WAYS];
   logic [DATA_W-1:0] w_data [WAYS];
   logic [WAYS-1:0]   fill_en, wr_en, inv_en;
   logic              touch_en, touch_left, mru_left, pick_right;
   logic              hit_any, hit_r, done;
   logic [DATA_W-1:0] done_data;
   logic              unused_off;

   assign unused_off = ^req_addr[OFF_W-1:0];

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      wbc_way #(.TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_way (
         .clk       (clk),
         .rst_n     (rst_n),
         .idx       (q_idx),
         .fill_en   (fill_en[g]),
         .fill_tag  (q_tag),
         .fill_data (mem_rsp_rdata),
         .wr_en     (wr_en[g]),
         .wr_data   (q_wdata),
         .inv_en    (inv_en[g]),
         .valid     (w_valid[g]),
         .dirty     (w_dirty[g]),
         .tag       (w_tag[g]),
         .data      (w_data[g])
      );
      assign hit[g] = w_valid[g] && (w_tag[g] == q_tag);
   end

   wbc_lru #(.IDX_W(IDX_W)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx        (q_idx),
      .touch_en   (touch_en),
      .touch_left (touch_left),
      .mru_left   (mru_left)
   );

   wbc_pick u_pick (
      .valid_l    (w_valid[0]),
      .valid_r    (w_valid[1]),
      .mru_left   (mru_left),
      .pick_right (pick_right)
   );

   assign hit_any   = |hit;
   assign hit_r     = hit[1];
   assign req_ready = (state == S_IDLE);

   always_comb begin
      nxt           = state;
      fill_en       = '0;
      wr_en         = '0;
      inv_en        = '0;
      touch_en      = 1'b0;
      touch_left    = 1'b0;
      done          = 1'b0;
      done_data     = '0;
      mem_req_valid = 1'b0;
      mem_req_write = 1'b0;
      mem_req_addr  = {q_tag, q_idx, {OFF_W{1'b0}}};
      mem_req_wdata = q_wdata;
      case (state)
         S_IDLE:
            if (req_valid) nxt = S_LOOK;
         S_LOOK:
            case (q_op)
               OP_RD:
                  if (hit_any) begin
                     done       = 1'b1;
                     done_data  = w_data[hit_r];
                     touch_en   = 1'b1;
                     touch_left = !hit_r;
                     nxt        = S_IDLE;
                  end else if (w_valid[pick_right] && w_dirty[pick_right]) begin
                     nxt = S_WB;
                  end else begin
                     nxt = S_FETCH;
                  end
               OP_WR:
                  if (hit_any) begin
                     wr_en[hit_r] = 1'b1;
                     touch_en     = 1'b1;
                     touch_left   = !hit_r;
                     done         = 1'b1;
                     nxt          = S_IDLE;
                  end else begin
                     nxt = S_WMISS;
                  end
               default: begin
                  if (hit_any) inv_en[hit_r] = 1'b1;
                  done = 1'b1;
                  nxt  = S_IDLE;
               end
            endcase
         S_WB: begin
            mem_req_valid = 1'b1;
            mem_req_write = 1'b1;
            mem_req_addr  = {w_tag[victim_q], q_idx, {OFF_W{1'b0}}};
            mem_req_wdata = w_data[victim_q];
            if (mem_req_ready) nxt = S_FETCH;
         end
         S_FETCH: begin
            mem_req_valid = 1'b1;
            if (mem_req_ready) nxt = S_WAIT;
         end
         S_WAIT:
            if (mem_rsp_valid) begin
               fill_en[victim_q] = 1'b1;
               touch_en          = 1'b1;
               touch_left        = !victim_q;
               done              = 1'b1;
               done_data         = mem_rsp_rdata;
               nxt               = S_IDLE;
            end
         S_WMISS: begin
            mem_req_valid = 1'b1;
            mem_req_write = 1'b1;
            if (mem_req_ready) begin
               done = 1'b1;
               nxt  = S_IDLE;
            end
         end
         default:
            nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         q_op      <= '0;
         q_tag     <= '0;
         q_idx     <= '0;
         q_wdata   <= '0;
         victim_q  <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         state     <= nxt;
         rsp_valid <= done;
         if (done) rsp_rdata <= done_data;
         if (state == S_IDLE && req_valid) begin
            q_op    <= req_op;
            q_tag   <= req_addr[ADDR_W-1 -: TAG_W];
            q_idx   <= req_addr[OFF_W +: IDX_W];
            q_wdata <= req_wdata;
         end
         if (state == S_LOOK) victim_q <= pick_right;
      end
   end
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_write,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [DATA_W-1:0] mem_req_wdata
);
   a_r1_idle_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid);

   a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r10_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r10_rsp_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);

   a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr)
          && $stable(mem_req_wdata)));
endmodule

bind wbc_cache wbc_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/wbc_cache_test.sv
module wbc_cache_test;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'd0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic        mem_req_write;
   logic [31:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_rdata;

   int total = 0;
   int bad = 0;
   bit over = 0;

   logic [31:0] bmem [64];
   logic [31:0] emem [64];
   bit          r_v  [4][2];
   bit          r_d  [4][2];
   logic [27:0] r_tag[4][2];
   logic [31:0] r_dat[4][2];
   bit          r_l  [4];

   int wr_cnt, rd_cnt, pend;
   bit rd_seen, order_bad;
   logic [5:0] pend_addr;

   always #(PERIOD/2) clk = ~clk;

   wbc_cache uut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int t, input int i);
      return 32'((t << 4) | (i << 2));
   endfunction

   // backing memory with random backpressure and latency
   initial begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_rdata = '0;
      pend = 0;
      pend_addr = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_rdata = bmem[pend_addr];
            end
         end
         mem_req_ready = ($urandom % 3) != 0;
         if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
               bmem[mem_req_addr[7:2]] = mem_req_wdata;
               wr_cnt++;
               if (rd_seen) order_bad = 1'b1;
            end else begin
               rd_cnt++;
               rd_seen = 1'b1;
               pend_addr = mem_req_addr[7:2];
               pend = 1 + int'($urandom % 3);
            end
         end
      end
   end

   task automatic do_op(input logic [1:0] op, input logic [31:0] addr,
                        input logic [31:0] wd, input string req);
      int idx, h, v, ew, er, n, mism;
      logic [27:0] t;
      logic [31:0] erd;
      idx = int'(addr[3:2]);
      t = addr[31:4];
      h = -1; ew = 0; er = 0; erd = '0;
      for (int w = 0; w < 2; w++)
         if (r_v[idx][w] && r_tag[idx][w] == t) h = w;
      case (op)
         2'd0: begin
            if (h >= 0) begin
               erd = r_dat[idx][h];
               r_l[idx] = (h == 0);
            end else begin
               if (!r_v[idx][0]) v = 0;
               else if (!r_v[idx][1]) v = 1;
               else v = r_l[idx] ? 1 : 0;
               if (r_v[idx][v] && r_d[idx][v]) begin
                  ew = 1;
                  emem[{r_tag[idx][v][3:0], 2'(idx)}] = r_dat[idx][v];
               end
               er = 1;
               erd = emem[addr[7:2]];
               r_v[idx][v] = 1'b1;
               r_d[idx][v] = 1'b0;
               r_tag[idx][v] = t;
               r_dat[idx][v] = erd;
               r_l[idx] = (v == 0);
            end
         end
         2'd1: begin
            if (h >= 0) begin
               r_dat[idx][h] = wd;
               r_d[idx][h] = 1'b1;
               r_l[idx] = (h == 0);
            end else begin
               ew = 1;
               emem[addr[7:2]] = wd;
            end
         end
         default:
            if (h >= 0) begin
               r_v[idx][h] = 1'b0;
               r_d[idx][h] = 1'b0;
            end
      endcase

      wr_cnt = 0; rd_cnt = 0; rd_seen = 1'b0; order_bad = 1'b0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_op = op;
      req_addr = addr;
      req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk(rsp_valid, req, "R10 completion pulse", 32'(rsp_valid), 32'd1);
      if (op == 2'd0) chk(rsp_rdata == erd, req, "read data", rsp_rdata, erd);
      chk(wr_cnt == ew, req, "memory writes", 32'(wr_cnt), 32'(ew));
      chk(rd_cnt == er, req, "memory reads", 32'(rd_cnt), 32'(er));
      chk(!order_bad, req, "R9 write-back before fill", 32'(order_bad), 32'd0);
      mism = -1;
      for (int i = 63; i >= 0; i--) if (bmem[i] !== emem[i]) mism = i;
      if (mism >= 0) chk(1'b0, req, "memory word", bmem[mism], emem[mism]);
      else chk(1'b1, req, "memory word", '0, '0);
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!over) begin
         over = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 64; i++) begin
         bmem[i] = 32'(100 + 7 * i);
         emem[i] = bmem[i];
      end
      for (int i = 0; i < 4; i++) begin
         r_l[i] = 1'b0;
         for (int w = 0; w < 2; w++) begin
            r_v[i][w] = 1'b0; r_d[i][w] = 1'b0; r_tag[i][w] = '0; r_dat[i][w] = '0;
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
      chk(mem_req_valid == 1'b0, "R1", "no memory request", 32'(mem_req_valid), 32'd0);
      chk(rsp_valid == 1'b0, "R1", "no response", 32'(rsp_valid), 32'd0);

      do_op(2'd0, mk(1, 0), 0, "R3 fill left first");
      do_op(2'd0, mk(2, 0), 0, "R3 fill right");
      do_op(2'd0, mk(1, 0), 0, "R2 read hit");
      do_op(2'd1, mk(1, 0), 32'hAAAA_0001, "R8 write hit");
      do_op(2'd0, mk(1, 0), 0, "R2 read back dirty word");
      do_op(2'd0, mk(3, 0), 0, "R4 replace right when left recent");
      do_op(2'd0, mk(2, 0), 0, "R9 dirty left evicted");
      do_op(2'd1, mk(3, 0), 32'hBBBB_0002, "R5 write hit marks right");
      do_op(2'd2, mk(3, 0), 0, "R6 invalidate dirty word");
      do_op(2'd0, mk(1, 0), 0, "R6 invalid way preferred over recency");
      do_op(2'd0, mk(3, 0), 0, "R4 replace left when right recent");
      do_op(2'd2, mk(9, 2), 0, "R6 invalidate miss no effect");
      do_op(2'd1, mk(5, 1), 32'h1234_5678, "R7 write miss to memory");
      do_op(2'd0, mk(5, 1), 0, "R7 no allocate then read miss");
      do_op(2'd1, mk(6, 1), 32'hCAFE_0003, "R7 write miss second");

      for (int k = 0; k < 400; k++) begin
         int r;
         logic [1:0] op;
         r = int'($urandom % 100);
         op = (r < 50) ? 2'd0 : (r < 85) ? 2'd1 : 2'd2;
         do_op(op, mk(int'($urandom % 4), int'($urandom % 4)), $urandom,
               "R11 random stream");
      end

      if (!over) begin
         over = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule